// File: doc/BRIEF.md
# Multiplexed Seven-Segment Display Scanner

This block drives a row of common-anode seven-segment digits that share one segment bus. It lights one digit at a time. A host fills a small table with one BCD code per digit through a write strobe, an address and a 4-bit value. The scanner then walks the digits in a fixed rhythm. Each digit gets one slot of a fixed number of clock cycles. The slot opens with a short dark gap, with every digit off and every segment high, so the previous pattern cannot ghost onto the next digit. For the rest of the slot the digit shows its decoded pattern.

Both the segment lines and the digit enables are active low, as PNP anode switches and sinking segment drivers expect. One frame lasts the digit count times the slot length. The default of 8 digits and 250000 cycles per slot gives a 2 ms slot at 125 MHz, a 16 ms frame and about 62 frames per second. That is inside the 40 to 200 Hz band needed to avoid visible flicker.

Top module: `seg_scan_mux`

## Requirements
- R1: While `rst` is high, and in the cycle it is released, `dig_n` is all ones and `seg_n` is 7'h7F. Reset loads the code 15 into every table entry, so each digit shows blank until it is written.
- R2: At most one bit of `dig_n` is low in any cycle.
- R3: Every slot lasts DWELL cycles. In its first GAP cycles (GAP ≥ 1, GAP < DWELL) `dig_n` is all ones and `seg_n` is all ones. In the remaining DWELL−GAP cycles one digit is enabled, and `dig_n` and `seg_n` hold steady.
- R4: Slots visit digits 0, 1, …, DIGITS−1 and then return to 0. Digit k is enabled by driving `dig_n[k]` low. A digit is enabled again exactly DIGITS×DWELL cycles after its previous enable.
- R5: Codes 0 to 9 show their numeral. `seg_n` bit 0 is segment a and bit 6 is segment g, and a lit segment is 0. The active-high patterns g..a are 0:3F, 1:06, 2:5B, 3:4F, 4:66, 5:6D, 6:7D, 7:07, 8:7F, 9:6F. `seg_n` is their complement.
- R6: Codes 10 to 15 show blank: `seg_n` stays 7'h7F while the digit is enabled.
- R7: A table write changes the display only from the start of that digit's next enable period. The entry is sampled on the clock edge that enables the digit, and a write on that same edge is not yet seen. A write during a lit period leaves `seg_n` unchanged for the rest of that period.
- R8: A write with `wr_addr` ≥ DIGITS is ignored and leaves every digit's display unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | AW = clog2(DIGITS) | Digit index to write |
| wr_bcd | input | 4 | BCD code to store |
| seg_n | output | 7 | Shared segments a..g in bits 0..6, active low |
| dig_n | output | DIGITS | Per-digit anode enables, active low |

## Verification
The bench builds the scanner with 5 digits, a 6-cycle slot and a 2-cycle gap. A frame is then only 30 cycles, so every cycle of many frames can be compared with an arithmetic model of slot position and captured code. With 5 digits the address field is 3 bits wide, which leaves addresses 5 to 7 free to probe the ignored-write rule. All 16 codes are written and displayed. Writes are also made in the middle of a lit period, and the scan period is measured between two enables of digit 0.

// File: rtl/seg_scan_mux.sv
module seg_scan_mux #(
  parameter int DIGITS = 8,
  parameter int DWELL  = 250000,
  parameter int GAP    = 2,
  localparam int AW = (DIGITS > 1) ? $clog2(DIGITS) : 1,
  localparam int CW = (DWELL > 1) ? $clog2(DWELL) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [3:0]        wr_bcd,
  output logic [6:0]        seg_n,
  output logic [DIGITS-1:0] dig_n
);

  logic [3:0]    tab [DIGITS];
  logic [CW-1:0] cnt;
  logic [AW-1:0] idx;

  wire addr_ok   = ({1'b0, wr_addr} < (AW+1)'(DIGITS));
  wire slot_end  = (cnt == CW'(DWELL - 1));
  wire gap_end   = (cnt == CW'(GAP - 1));
  wire last_dig  = (idx == AW'(DIGITS - 1));

  function automatic logic [6:0] glyph(input logic [3:0] v);
    case (v)
      4'd0: glyph = 7'h3F;
      4'd1: glyph = 7'h06;
      4'd2: glyph = 7'h5B;
      4'd3: glyph = 7'h4F;
      4'd4: glyph = 7'h66;
      4'd5: glyph = 7'h6D;
      4'd6: glyph = 7'h7D;
      4'd7: glyph = 7'h07;
      4'd8: glyph = 7'h7F;
      4'd9: glyph = 7'h6F;
      default: glyph = 7'h00;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      idx   <= '0;
      dig_n <= '1;
      seg_n <= '1;
      for (int i = 0; i < DIGITS; i++) tab[i] <= 4'hF;
    end else begin
      if (wr_en && addr_ok) tab[wr_addr] <= wr_bcd;
      if (slot_end) begin
        cnt   <= '0;
        idx   <= last_dig ? '0 : idx + 1'b1;
        dig_n <= '1;
        seg_n <= '1;
      end else begin
        cnt <= cnt + 1'b1;
        if (gap_end) begin
          dig_n <= ~(DIGITS'(1) << idx);
          seg_n <= ~glyph(tab[idx]);
        end
      end
    end
  end

  assert_one_digit_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~dig_n));

  assert_dark_gap_R3: assert property (@(posedge clk) disable iff (rst)
    (dig_n == '1) |-> (seg_n == 7'h7F));

  assert_steady_lit_R7: assert property (@(posedge clk) disable iff (rst)
    (dig_n != '1 && $past(dig_n) != '1) |-> ($stable(dig_n) && $stable(seg_n)));

  assert_slot_bound_R4: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, cnt} < (CW+1)'(DWELL)));

endmodule

// File: tb/test_seg_scan_mux.sv
module test_seg_scan_mux;
  localparam int DIGITS = 5;
  localparam int DWELL  = 6;
  localparam int GAP    = 2;
  localparam int AW     = 3;
  localparam int FRAME  = DIGITS * DWELL;

  logic clk = 0;
  logic rst = 1;
  logic wr_en = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [3:0] wr_bcd = '0;
  logic [6:0] seg_n;
  logic [DIGITS-1:0] dig_n;

  int errors = 0, checks = 0;
  int t = 0;
  logic [3:0] mtab [DIGITS];
  logic [3:0] capv = 4'hF;
  string ctx = "";
  bit run = 0;

  always #4 clk = ~clk;

  seg_scan_mux #(.DIGITS(DIGITS), .DWELL(DWELL), .GAP(GAP)) i_seg_scan_mux (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_bcd(wr_bcd),
    .seg_n(seg_n), .dig_n(dig_n));

  function automatic logic [6:0] pat(input logic [3:0] v);
    logic [6:0] p;
    case (v)
      0: p = 7'h3F; 1: p = 7'h06; 2: p = 7'h5B; 3: p = 7'h4F; 4: p = 7'h66;
      5: p = 7'h6D; 6: p = 7'h7D; 7: p = 7'h07; 8: p = 7'h7F; 9: p = 7'h6F;
      default: p = 7'h00;
    endcase
    return ~p;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0d)", req, act, exp, t);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      t = 0;
      for (int i = 0; i < DIGITS; i++) mtab[i] = 4'hF;
    end else begin
      t = t + 1;
      if (t % DWELL == GAP) capv = mtab[(t / DWELL) % DIGITS];
      if (wr_en && wr_addr < DIGITS) mtab[wr_addr] = wr_bcd;
    end
  end

  always @(negedge clk) begin
    if (run && !rst) begin
      automatic bit lit = (t % DWELL) >= GAP;
      automatic int d = (t / DWELL) % DIGITS;
      automatic logic [DIGITS-1:0] ed = lit ? ~(DIGITS'(1) << d) : '1;
      automatic logic [6:0] es = lit ? pat(capv) : 7'h7F;
      automatic string r = (ctx != "") ? ctx : (!lit ? "R3" : (capv < 10 ? "R5" : "R6"));
      chk(lit ? "R4" : "R3", dig_n, ed);
      chk(r, seg_n, es);
      chk("R2", ($countones(~dig_n) <= 1), 1);
    end
  end

  task automatic wr(input int a, input int v);
    @(negedge clk);
    wr_en = 1; wr_addr = AW'(a); wr_bcd = 4'(v);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    wait_cyc(3);
    chk("R1", dig_n, {DIGITS{1'b1}});
    chk("R1", seg_n, 7'h7F);
    rst = 0;
    #1;
    chk("R1", dig_n, {DIGITS{1'b1}});
    run = 1;
    ctx = "R1";
    wait_cyc(FRAME);
    ctx = "";
    for (int r = 0; r < 4; r++) begin
      for (int d = 0; d < DIGITS; d++) wr(d, (r * DIGITS + d) % 16);
      wait_cyc(2 * FRAME);
    end
    for (int d = 0; d < DIGITS; d++) wr(d, d + 3);
    wait_cyc(FRAME);
    n = 0;
    while (dig_n != ~DIGITS'(4) && n < 1000) begin @(negedge clk); n++; end
    ctx = "R7";
    wr(2, 9);
    wait_cyc(2 * FRAME);
    ctx = "R8";
    wr(6, 8);
    wr(7, 0);
    wr(5, 1);
    wait_cyc(2 * FRAME);
    ctx = "";
    n = 0;
    while (dig_n != ~DIGITS'(1) && n < 1000) begin @(negedge clk); n++; end
    while (dig_n == ~DIGITS'(1) && n < 1000) begin @(negedge clk); n++; end
    n = 0;
    while (dig_n != ~DIGITS'(1) && n < 1000) begin @(negedge clk); n++; end
    chk("R4", n + (DWELL - GAP), FRAME);
    wait_cyc(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule